// File: doc/BRIEF.md
# Vector Floating-Point Status Register

This block holds the 128-bit floating-point status and control state of a four-lane vector unit. The state is four 32-bit words. Execution lanes report exceptions into it as sticky flags. The flags are per single-precision lane or per double-precision slice, with a separate divide-by-zero path. The two double-precision slices each own a 2-bit rounding-mode field. Software can overwrite the whole register, but only a fixed set of legal bits in each word survives the write.

The layout is deliberately irregular. Single-precision flags sit in the low bits of every word. Double-precision flags sit in the two middle words. Divide-by-zero bits are packed into word 0. The rounding fields live in word 3. Every change made in a cycle is visible on the full-width read port from the next cycle.

If a software write, a rounding update and flag requests arrive in the same cycle, they are applied in that order. A slice index that names no existing double slice makes its request void, and the block reports it with a one-cycle error pulse.

Top module: `vfp_status_reg`

## Requirements
- R1: Reset (`rst_n` low at a clock edge) clears all 128 bits of the register and the error pulse.
- R2: Bit k of `sp_flag_set[3n+2:3n]` sets bit k of word n for single lane n. Bit 2 is overflow, bit 1 is underflow and bit 0 is the different-result flag.
- R3: When `dp_set_vld` is high and `dp_set_slice` is s (0 or 1), `dp_set_flags[5:0]` is ORed into bits 13:8 of word 1+s. The flag order from bit 13 down is overflow, underflow, inexact, invalid, NaN, denormal.
- R4: `dz_set[n]` sets bit 8+n of word 0.
- R5: Flag requests only OR into the register and never clear a bit. With no software write and no rounding update, no bit falls.
- R6: A rounding update for slice s (0 or 1) replaces bits 9+2s:8+2s of word 3 with `rnd_wr_mode` (mode bit 0 goes to bit 8+2s) and leaves every other bit unchanged.
- R7: A software write loads words 0 and 3 masked by 0x00000F07 and words 1 and 2 masked by 0x00003F07, where word n is `sw_wr_data[32n+31:32n]`. All other bits are zero.
- R8: In one cycle, the software write is applied first, then the rounding update, then all flag requests are ORed in.
- R9: A double-flag request or rounding update whose slice index is greater than 1 changes nothing. `slice_err` is high for exactly the cycle after such a request.
- R10: `rd_data` is the whole register unmodified, and each update shows on it from the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sp_flag_set | input | 12 | Single-precision flag set requests, 3 bits per lane |
| dz_set | input | 4 | Divide-by-zero set request per single lane |
| dp_set_vld | input | 1 | Double-precision flag request valid |
| dp_set_slice | input | 2 | Double slice index of the flag request |
| dp_set_flags | input | 6 | Double-precision flags to set |
| rnd_wr_vld | input | 1 | Rounding-mode update valid |
| rnd_wr_slice | input | 2 | Double slice index of the rounding update |
| rnd_wr_mode | input | 2 | New rounding mode |
| sw_wr_vld | input | 1 | Software whole-register write valid |
| sw_wr_data | input | 128 | Software write data |
| rd_data | output | 128 | Full register contents |
| slice_err | output | 1 | One-cycle pulse after an out-of-range slice index |

## Verification
The bench builds the block with its defaults: four lanes, two double slices and a 2-bit slice index. The 2-bit index makes the illegal values 2 and 3 reachable, so both the ignored-request path and the error pulse are driven. The random phase mixes software writes, rounding updates and flag requests in the same cycle, so the write-then-replace-then-OR ordering is checked against the bench's own word-by-word model.

// File: rtl/vfpsr_pkg.sv
package vfpsr_pkg;
  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 4;
  localparam int REG_W       = WORD_W * NUM_WORDS;
  localparam int SP_FLAG_W   = 3;
  localparam int DP_FLAG_W   = 6;
  localparam int DP_FLAG_LSB = 8;
  localparam int DZ_LSB      = 8;
  localparam int RND_LSB     = 8;
  localparam int RND_W       = 2;
  localparam int RND_WORD    = 3;
  localparam int DP_WORD0    = 1;
  localparam logic [WORD_W-1:0] OUTER_KEEP = 32'h0000_0F07;
  localparam logic [WORD_W-1:0] INNER_KEEP = 32'h0000_3F07;

  typedef logic [REG_W-1:0] fpsr_t;

  // Legal bits of the whole register (outer words 0/3, inner words 1/2)
  function automatic fpsr_t keep_mask();
    return {OUTER_KEEP, INNER_KEEP, INNER_KEEP, OUTER_KEEP};
  endfunction

  function automatic fpsr_t sp_place(int lane, logic [SP_FLAG_W-1:0] f);
    fpsr_t m = '0;
    m[lane*WORD_W +: SP_FLAG_W] = f;
    return m;
  endfunction

  function automatic fpsr_t dz_place(int lane, logic b);
    fpsr_t m = '0;
    m[DZ_LSB + lane] = b;
    return m;
  endfunction

  function automatic fpsr_t dp_place(int slice, logic [DP_FLAG_W-1:0] f);
    fpsr_t m = '0;
    m[(DP_WORD0 + slice)*WORD_W + DP_FLAG_LSB +: DP_FLAG_W] = f;
    return m;
  endfunction

  function automatic fpsr_t rnd_place(int slice, logic [RND_W-1:0] v);
    fpsr_t m = '0;
    m[RND_WORD*WORD_W + RND_LSB + RND_W*slice +: RND_W] = v;
    return m;
  endfunction
endpackage

// File: rtl/vfpsr_set_decode.sv
module vfpsr_set_decode
  import vfpsr_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DP_SLICES = 2,
  parameter int SLICE_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES*SP_FLAG_W-1:0] sp_flags,
  input  logic [LANES-1:0]           dz,
  input  logic                       dp_vld,
  input  logic [SLICE_W-1:0]         dp_slice,
  input  logic [DP_FLAG_W-1:0]       dp_flags,
  input  logic                       rnd_bad,
  output fpsr_t                      set_mask,
  output logic                       dp_bad,
  output logic                       err_o
);
  fpsr_t lane_mask [LANES];
  fpsr_t dp_mask;
  logic  was_run;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l] = sp_place(l, sp_flags[l*SP_FLAG_W +: SP_FLAG_W]) |
                          dz_place(l, dz[l]);
  end

  always_comb begin
    dp_mask = '0;
    for (int s = 0; s < DP_SLICES; s++) begin
      if (dp_vld && (dp_slice == SLICE_W'(s))) dp_mask = dp_mask | dp_place(s, dp_flags);
    end
  end

  always_comb begin
    set_mask = dp_mask;
    for (int l = 0; l < LANES; l++) set_mask = set_mask | lane_mask[l];
  end

  assign dp_bad = dp_vld && (dp_slice >= SLICE_W'(DP_SLICES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_o   <= 1'b0;
      was_run <= 1'b0;
    end else begin
      err_o   <= dp_bad | rnd_bad;
      was_run <= 1'b1;
    end
  end

  // R9: an illegal slice is followed by an error pulse, and only then
  a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n || !was_run)
    (dp_bad || rnd_bad) |=> err_o);
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n || !was_run)
    err_o |-> $past(dp_bad || rnd_bad));
  // R9: a void double request contributes no double-flag bits
  a_r9_void_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
    dp_bad |-> (dp_mask == '0));
endmodule

// File: rtl/vfpsr_round_ctl.sv
module vfpsr_round_ctl
  import vfpsr_pkg::*;
#(
  parameter int DP_SLICES = 2,
  parameter int SLICE_W   = 2
) (
  input  logic               rnd_vld,
  input  logic [SLICE_W-1:0] rnd_slice,
  input  logic [RND_W-1:0]   rnd_mode,
  output logic               rnd_apply,
  output fpsr_t              rnd_clr,
  output fpsr_t              rnd_val,
  output logic               rnd_bad
);
  always_comb begin
    rnd_clr   = '0;
    rnd_val   = '0;
    rnd_apply = 1'b0;
    for (int s = 0; s < DP_SLICES; s++) begin
      if (rnd_vld && (rnd_slice == SLICE_W'(s))) begin
        rnd_apply = 1'b1;
        rnd_clr   = rnd_place(s, '1);
        rnd_val   = rnd_place(s, rnd_mode);
      end
    end
  end

  assign rnd_bad = rnd_vld && !rnd_apply;

  // R6: only one 2-bit field is ever replaced
  always_comb begin
    a_r6_single_field: assert ($countones(rnd_clr) == (rnd_apply ? RND_W : 0));
  end
endmodule

// File: rtl/vfpsr_store.sv
module vfpsr_store
  import vfpsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sw_vld,
  input  fpsr_t sw_data,
  input  logic  rnd_apply,
  input  fpsr_t rnd_clr,
  input  fpsr_t rnd_val,
  input  fpsr_t set_mask,
  output fpsr_t q
);
  fpsr_t base;
  fpsr_t after_rnd;
  fpsr_t nxt;
  logic  was_run;

  // Ordering: software write, then rounding replace, then sticky OR
  assign base      = sw_vld ? (sw_data & keep_mask()) : q;
  assign after_rnd = (base & ~rnd_clr) | rnd_val;
  assign nxt       = after_rnd | set_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= '0;
      was_run <= 1'b0;
    end else begin
      q       <= nxt;
      was_run <= 1'b1;
    end
  end

  // R5: without a write or rounding update no bit falls
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n || !was_run)
    (!sw_vld && !rnd_apply) |=> ((q & $past(q)) == $past(q)));
  // R7: bits outside the legal layout are never set
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & ~keep_mask()) == '0));
  // R6: the replaced rounding field holds the requested mode afterwards
  a_r6_field_loaded: assert property (@(posedge clk) disable iff (!rst_n || !was_run)
    rnd_apply |=> ((q & $past(rnd_clr)) == $past(rnd_val)));
  // R8: requested set bits are present after any same-cycle write
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n || !was_run)
    1'b1 |=> ((q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/vfp_status_reg.sv
module vfp_status_reg
  import vfpsr_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DP_SLICES = 2,
  parameter int SLICE_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES*SP_FLAG_W-1:0] sp_flag_set,
  input  logic [LANES-1:0]           dz_set,
  input  logic                       dp_set_vld,
  input  logic [SLICE_W-1:0]         dp_set_slice,
  input  logic [DP_FLAG_W-1:0]       dp_set_flags,
  input  logic                       rnd_wr_vld,
  input  logic [SLICE_W-1:0]         rnd_wr_slice,
  input  logic [RND_W-1:0]           rnd_wr_mode,
  input  logic                       sw_wr_vld,
  input  logic [REG_W-1:0]           sw_wr_data,
  output logic [REG_W-1:0]           rd_data,
  output logic                       slice_err
);
  fpsr_t set_mask;
  fpsr_t rnd_clr;
  fpsr_t rnd_val;
  fpsr_t state_q;
  logic  rnd_apply;
  logic  rnd_bad;
  logic  dp_bad;

  vfpsr_set_decode #(.LANES(LANES), .DP_SLICES(DP_SLICES), .SLICE_W(SLICE_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .sp_flags (sp_flag_set),
    .dz       (dz_set),
    .dp_vld   (dp_set_vld),
    .dp_slice (dp_set_slice),
    .dp_flags (dp_set_flags),
    .rnd_bad  (rnd_bad),
    .set_mask (set_mask),
    .dp_bad   (dp_bad),
    .err_o    (slice_err)
  );

  vfpsr_round_ctl #(.DP_SLICES(DP_SLICES), .SLICE_W(SLICE_W)) u_rnd (
    .rnd_vld   (rnd_wr_vld),
    .rnd_slice (rnd_wr_slice),
    .rnd_mode  (rnd_wr_mode),
    .rnd_apply (rnd_apply),
    .rnd_clr   (rnd_clr),
    .rnd_val   (rnd_val),
    .rnd_bad   (rnd_bad)
  );

  vfpsr_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_vld    (sw_wr_vld),
    .sw_data   (sw_wr_data),
    .rnd_apply (rnd_apply),
    .rnd_clr   (rnd_clr),
    .rnd_val   (rnd_val),
    .set_mask  (set_mask),
    .q         (state_q)
  );

  assign rd_data = state_q;

  // R9: an ignored double request leaves the register unchanged when alone
  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_bad && !rnd_wr_vld && !sw_wr_vld && (sp_flag_set == '0) && (dz_set == '0))
      |=> $stable(rd_data));
endmodule

// File: tb/vfp_status_reg_test.sv
module vfp_status_reg_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  sp_flag_set = '0;
  logic [3:0]   dz_set = '0;
  logic         dp_set_vld = 1'b0;
  logic [1:0]   dp_set_slice = '0;
  logic [5:0]   dp_set_flags = '0;
  logic         rnd_wr_vld = 1'b0;
  logic [1:0]   rnd_wr_slice = '0;
  logic [1:0]   rnd_wr_mode = '0;
  logic         sw_wr_vld = 1'b0;
  logic [127:0] sw_wr_data = '0;
  logic [127:0] rd_data;
  logic         slice_err;

  vfp_status_reg uut (
    .clk(clk), .rst_n(rst_n), .sp_flag_set(sp_flag_set), .dz_set(dz_set),
    .dp_set_vld(dp_set_vld), .dp_set_slice(dp_set_slice), .dp_set_flags(dp_set_flags),
    .rnd_wr_vld(rnd_wr_vld), .rnd_wr_slice(rnd_wr_slice), .rnd_wr_mode(rnd_wr_mode),
    .sw_wr_vld(sw_wr_vld), .sw_wr_data(sw_wr_data), .rd_data(rd_data), .slice_err(slice_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] mw [4];
  logic exp_err;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model: words updated in write / round / OR order
  function automatic void model_step();
    logic [31:0] n [4];
    for (int w = 0; w < 4; w++) n[w] = mw[w];
    if (sw_wr_vld) begin
      n[0] = sw_wr_data[31:0]   & 32'h0F07;
      n[1] = sw_wr_data[63:32]  & 32'h3F07;
      n[2] = sw_wr_data[95:64]  & 32'h3F07;
      n[3] = sw_wr_data[127:96] & 32'h0F07;
    end
    if (rnd_wr_vld && rnd_wr_slice < 2) begin
      n[3][8 + 2*rnd_wr_slice] = rnd_wr_mode[0];
      n[3][9 + 2*rnd_wr_slice] = rnd_wr_mode[1];
    end
    for (int l = 0; l < 4; l++) begin
      n[l] = n[l] | {29'b0, sp_flag_set[3*l +: 3]};
      n[0][8 + l] = n[0][8 + l] | dz_set[l];
    end
    if (dp_set_vld && dp_set_slice < 2)
      n[1 + dp_set_slice] = n[1 + dp_set_slice] | {18'b0, dp_set_flags, 8'b0};
    exp_err = (dp_set_vld && dp_set_slice > 1) || (rnd_wr_vld && rnd_wr_slice > 1);
    for (int w = 0; w < 4; w++) mw[w] = n[w];
  endfunction

  function automatic logic [127:0] model_vec();
    return {mw[3], mw[2], mw[1], mw[0]};
  endfunction

  task automatic idle();
    sp_flag_set = '0; dz_set = '0; dp_set_vld = 0; dp_set_slice = '0; dp_set_flags = '0;
    rnd_wr_vld = 0; rnd_wr_slice = '0; rnd_wr_mode = '0; sw_wr_vld = 0; sw_wr_data = '0;
  endtask

  task automatic step(string req);
    model_step();
    @(negedge clk);
    chk(req, rd_data, model_vec());
    chk({req, " err"}, {127'b0, slice_err}, {127'b0, exp_err});
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int w = 0; w < 4; w++) mw[w] = '0;
    exp_err = 0;
    chk("R1 reset", rd_data, '0);
    chk("R1 reset err", {127'b0, slice_err}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();

    sp_flag_set = {3'b101, 3'b010, 3'b001, 3'b110}; step("R2 lane flags");
    dz_set = 4'b1001; step("R4 divide-by-zero");
    dp_set_vld = 1; dp_set_slice = 0; dp_set_flags = 6'h2A; step("R3 slice0");
    dp_set_vld = 1; dp_set_slice = 1; dp_set_flags = 6'h15; step("R3 slice1");
    step("R5 idle keeps bits");
    sp_flag_set = 12'h001; dz_set = 4'b0001; step("R5 reset bits stay");
    rnd_wr_vld = 1; rnd_wr_slice = 0; rnd_wr_mode = 2'b11; step("R6 slice0 mode3");
    rnd_wr_vld = 1; rnd_wr_slice = 1; rnd_wr_mode = 2'b10; step("R6 slice1 mode2");
    rnd_wr_vld = 1; rnd_wr_slice = 0; rnd_wr_mode = 2'b01; step("R6 slice0 mode1");
    sw_wr_vld = 1; sw_wr_data = '1; step("R7 all ones");
    sw_wr_vld = 1; sw_wr_data = 128'hDEADBEEF_12345678_CAFEF00D_89ABCDEF; step("R7 pattern");
    sw_wr_vld = 1; sw_wr_data = '0; sp_flag_set = 12'h804; dz_set = 4'b0100;
    dp_set_vld = 1; dp_set_slice = 1; dp_set_flags = 6'h21;
    rnd_wr_vld = 1; rnd_wr_slice = 1; rnd_wr_mode = 2'b11; step("R8 same-cycle order");
    sw_wr_vld = 1; sw_wr_data = '1; rnd_wr_vld = 1; rnd_wr_slice = 0; rnd_wr_mode = 2'b00;
    step("R8 write then round");
    sw_wr_vld = 1; sw_wr_data = '0; step("R7 clear");
    dp_set_vld = 1; dp_set_slice = 2; dp_set_flags = 6'h3F; step("R9 bad dp slice");
    step("R9 pulse ends");
    rnd_wr_vld = 1; rnd_wr_slice = 3; rnd_wr_mode = 2'b11; step("R9 bad rnd slice");

    for (int i = 0; i < 400; i++) begin
      sw_wr_vld    = ($urandom % 8) == 0;
      sw_wr_data   = {$urandom, $urandom, $urandom, $urandom};
      rnd_wr_vld   = ($urandom % 4) == 0;
      rnd_wr_slice = 2'($urandom);
      rnd_wr_mode  = 2'($urandom);
      dp_set_vld   = ($urandom % 3) == 0;
      dp_set_slice = 2'($urandom);
      dp_set_flags = 6'($urandom & $urandom);
      sp_flag_set  = 12'($urandom & $urandom & $urandom);
      dz_set       = 4'($urandom & $urandom);
      step("R10 random");
    end

    sp_flag_set = '1; dz_set = '1; step("R10 before reset");
    do_reset();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule